// File: doc/BRIEF.md
# Backplane Slave Bridge to a Shared 16-bit Buffer

This block lets a host on a 32-bit multiplexed address/data backplane read and write a 16-bit local bus that it shares with a network controller's DMA engine. At the start of a cycle it captures the address and the read/write mode. It accepts the cycle only when the top address byte matches the code formed from the slot identity pins. It then requests the local bus from a built-in arbiter, which always favours the DMA side. Once it holds the bus, it performs two 16-bit local accesses and ends the backplane cycle with a one-clock acknowledge.

Backplane data is active-low, and its byte order differs from the local bus. The bridge inverts every data bit in both directions and reverses the four bytes of each word. A 32-bit host write therefore becomes two local writes, and two local reads are merged into one host word.

Three local targets are decoded from the captured address: the buffer RAM, a controller register window and a 256 x 8 identity/configuration ROM. The RAM address width is a parameter. The default of 13 bits gives 8K words, and 15 bits gives 32K words.

Top module: `bpSlaveBridge`

## Requirements
- R1: A cycle is accepted only when `startN` is low with `adInN[31:24]` equal to `{4'hF, slotId}`, read without inversion. For any other top byte, no acknowledge is given, `adOe` stays 0 and no local access is made.
- R2: The address and mode are captured on the clock where the start is accepted. Values on `adInN` after that clock do not change which location is accessed. Address bits 23..0 are taken as `~adInN[23:0]`.
- R3: `rdMode` captured at the start selects the direction: 1 means read and 0 means write.
- R4: A local select (`locRamSel`, `locRegSel`, `locRomSel`) is raised only while `hostOwns` is 1. `hostOwns` and `dmaGnt` are never both 1.
- R5: If the local bus has no owner and `dmaReq` is 1, `dmaGnt` is given on the next clock, even while the host is also requesting. `hostOwns` rises only after a clock in which `dmaReq` was 0.
- R6: Once granted, the host keeps the bus through both local accesses, whatever `dmaReq` does. A waiting DMA request is then granted on the clock after the host's final step.
- R7: On a write, with d = `~adInN` in the data phase and k the word index, the local word at address 2k receives `{d[7:0], d[15:8]}` and the word at 2k+1 receives `{d[23:16], d[31:24]}`. `locWe` is 1 only together with a local select.
- R8: On a read, with e and o the words read from 2k and 2k+1, the host word ~`adOutN` equals `{o[7:0], o[15:8], e[7:0], e[15:8]}`.
- R9: `ackN` is low for exactly one clock per accepted cycle. On a read, `adOe` is 1 and `adOutN` is valid in that same clock. `adOe` is 0 at all other times and on writes.
- R10: Address bits 23..22 select the target: 00 is the RAM, with local address `{addr[RamAw:2], half}`; 01 is the register window, with `{addr[4:2], half}`; 1x is the ROM, with `{addr[8:2], half}`. Here half is 0 for the first access and 1 for the second.
- R11: Without DMA contention, the acknowledge comes on the 6th clock after the start clock. If the DMA holds the bus, the acknowledge comes 5 clocks after the clock in which `dmaReq` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slotId | input | 4 | Slot identity pins |
| startN | input | 1 | Cycle start strobe, active low |
| rdMode | input | 1 | Transfer mode at start: 1 read, 0 write |
| adInN | input | 32 | Multiplexed address/data from backplane (inverted data) |
| adOutN | output | 32 | Read data to backplane, inverted; all ones when not driven |
| adOe | output | 1 | Output enable for `adOutN` |
| ackN | output | 1 | Cycle acknowledge, active low, one clock |
| dmaReq | input | 1 | Local bus request from network DMA |
| dmaGnt | output | 1 | Local bus grant to network DMA |
| hostOwns | output | 1 | Local bus currently granted to the bridge |
| locAddr | output | RamAw | Local word address |
| locWrData | output | 16 | Local write data |
| locRdData | input | 16 | Local read data, valid the clock after the access |
| locWe | output | 1 | Local write enable |
| locRamSel | output | 1 | Buffer RAM select |
| locRegSel | output | 1 | Controller register window select |
| locRomSel | output | 1 | ID/configuration ROM select |

## Verification
Counting from the clock that accepts the start, the grant is registered one clock later and seen by the sequencer one clock after that. The two local accesses then take one clock each, and the second read word is registered one clock later. As a result, `ackN` and read data appear on the 6th clock. If the DMA holds the bus, they appear 5 clocks after `dmaReq` is released. The bench drives and samples on falling edges and counts those edges from the start. It checks the exact edge for every uncontended cycle and for each contention case, and it checks the edge after the acknowledge to confirm that the strobe has gone away. Grant ownership under contention is sampled at the fixed edges that these counts predict.

// File: rtl/bsbPkg.sv
package bsbPkg;

  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_REG = 2'd1,
    TGT_ROM = 2'd2
  } tgt_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchAddr;
    logic latchWr;
    logic issue;
    logic half;
    logic capLo;
    logic capHi;
    logic drive;
  } ctlStrb_t;

  function automatic logic [31:0] swapBytes(input logic [31:0] w);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      r[8*i +: 8] = w[8*(3-i) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/bsbArb.sv
module bsbArb (
  input  logic clk,
  input  logic rstN,
  input  logic dmaReq,
  input  logic hostReq,
  output logic dmaGnt,
  output logic hostGnt
);

  logic dmaNext;
  logic hostNext;

  // current owner keeps the bus while it requests; otherwise DMA wins
  always_comb begin
    dmaNext  = 1'b0;
    hostNext = 1'b0;
    if (dmaGnt && dmaReq) begin
      dmaNext = 1'b1;
    end else if (hostGnt && hostReq) begin
      hostNext = 1'b1;
    end else if (dmaReq) begin
      dmaNext = 1'b1;
    end else if (hostReq) begin
      hostNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaGnt  <= 1'b0;
      hostGnt <= 1'b0;
    end else begin
      dmaGnt  <= dmaNext;
      hostGnt <= hostNext;
    end
  end

endmodule

// File: rtl/bsbCtl.sv
module bsbCtl
  import bsbPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startHit,
  input  logic     hostGnt,
  output logic     hostReq,
  output ctlStrb_t strb
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARB,
    S_LO,
    S_HI,
    S_FIN,
    S_ACK
  } state_e;

  state_e state;
  state_e stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    hostReq   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (startHit) begin
          strb.latchAddr = 1'b1;
          stateNext      = S_ARB;
        end
      end
      S_ARB: begin
        hostReq      = 1'b1;
        strb.latchWr = 1'b1;
        if (hostGnt) stateNext = S_LO;
      end
      S_LO: begin
        hostReq    = 1'b1;
        strb.issue = 1'b1;
        stateNext  = S_HI;
      end
      S_HI: begin
        hostReq    = 1'b1;
        strb.issue = 1'b1;
        strb.half  = 1'b1;
        strb.capLo = 1'b1;
        stateNext  = S_FIN;
      end
      S_FIN: begin
        strb.capHi = 1'b1;
        stateNext  = S_ACK;
      end
      S_ACK: begin
        strb.drive = 1'b1;
        stateNext  = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/bsbDatapath.sv
module bsbDatapath
  import bsbPkg::*;
#(
  parameter int RamAw = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       slotId,
  input  logic             startN,
  input  logic             rdMode,
  input  logic [31:0]      adInN,
  input  ctlStrb_t         strb,
  output logic             startHit,
  output logic [31:0]      adOutN,
  output logic             adOe,
  output logic [RamAw-1:0] locAddr,
  output logic [15:0]      locWrData,
  input  logic [15:0]      locRdData,
  output logic             locWe,
  output logic             locRamSel,
  output logic             locRegSel,
  output logic             locRomSel
);

  localparam int IdxW = RamAw - 1;

  logic [7:0]      slotCode;
  logic [IdxW-1:0] idxQ;
  tgt_e            tgtQ;
  logic            readQ;
  logic [31:0]     wrQ;
  logic [15:0]     rdLo;
  logic [15:0]     rdHi;
  logic [31:0]     wrLocal;
  logic [23:0]     addrPlain;

  assign slotCode  = {4'hF, slotId};
  assign startHit  = !startN && (adInN[31:24] == slotCode);
  assign addrPlain = ~adInN[23:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      tgtQ  <= TGT_RAM;
      readQ <= 1'b0;
      wrQ   <= '0;
      rdLo  <= '0;
      rdHi  <= '0;
    end else begin
      if (strb.latchAddr) begin
        idxQ  <= addrPlain[RamAw:2];
        readQ <= rdMode;
        unique case (addrPlain[23:22])
          2'b00:   tgtQ <= TGT_RAM;
          2'b01:   tgtQ <= TGT_REG;
          default: tgtQ <= TGT_ROM;
        endcase
      end
      if (strb.latchWr) wrQ  <= ~adInN;
      if (strb.capLo)   rdLo <= locRdData;
      if (strb.capHi)   rdHi <= locRdData;
    end
  end

  // local word layout: first access carries the upper half of the swapped word
  assign wrLocal   = swapBytes(wrQ);
  assign locWrData = strb.half ? wrLocal[15:0] : wrLocal[31:16];

  always_comb begin
    unique case (tgtQ)
      TGT_RAM: locAddr = {idxQ, strb.half};
      TGT_REG: locAddr = RamAw'({idxQ[2:0], strb.half});
      default: locAddr = RamAw'({idxQ[6:0], strb.half});
    endcase
  end

  assign locRamSel = strb.issue && (tgtQ == TGT_RAM);
  assign locRegSel = strb.issue && (tgtQ == TGT_REG);
  assign locRomSel = strb.issue && (tgtQ == TGT_ROM);
  assign locWe     = strb.issue && !readQ;

  assign adOe   = strb.drive && readQ;
  assign adOutN = adOe ? ~swapBytes({rdLo, rdHi}) : '1;

endmodule

// File: rtl/bpSlaveBridge.sv
module bpSlaveBridge
  import bsbPkg::*;
#(
  parameter int RamAw = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       slotId,
  input  logic             startN,
  input  logic             rdMode,
  input  logic [31:0]      adInN,
  output logic [31:0]      adOutN,
  output logic             adOe,
  output logic             ackN,
  input  logic             dmaReq,
  output logic             dmaGnt,
  output logic             hostOwns,
  output logic [RamAw-1:0] locAddr,
  output logic [15:0]      locWrData,
  input  logic [15:0]      locRdData,
  output logic             locWe,
  output logic             locRamSel,
  output logic             locRegSel,
  output logic             locRomSel
);

  ctlStrb_t strb;
  logic     startHit;
  logic     hostReq;

  initial begin
    if (RamAw < 8 || RamAw > 22) $error("RamAw out of range");
  end

  bsbCtl ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startHit(startHit),
    .hostGnt (hostOwns),
    .hostReq (hostReq),
    .strb    (strb)
  );

  bsbArb arb_i (
    .clk    (clk),
    .rstN   (rstN),
    .dmaReq (dmaReq),
    .hostReq(hostReq),
    .dmaGnt (dmaGnt),
    .hostGnt(hostOwns)
  );

  bsbDatapath #(.RamAw(RamAw)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .slotId   (slotId),
    .startN   (startN),
    .rdMode   (rdMode),
    .adInN    (adInN),
    .strb     (strb),
    .startHit (startHit),
    .adOutN   (adOutN),
    .adOe     (adOe),
    .locAddr  (locAddr),
    .locWrData(locWrData),
    .locRdData(locRdData),
    .locWe    (locWe),
    .locRamSel(locRamSel),
    .locRegSel(locRegSel),
    .locRomSel(locRomSel)
  );

  assign ackN = ~strb.drive;

endmodule

// File: rtl/bpSlaveBridgeChk.sv
module bpSlaveBridgeChk (
  input logic clk,
  input logic rstN,
  input logic ackN,
  input logic adOe,
  input logic dmaReq,
  input logic dmaGnt,
  input logic hostOwns,
  input logic locWe,
  input logic locRamSel,
  input logic locRegSel,
  input logic locRomSel
);

  logic anySel;
  assign anySel = locRamSel | locRegSel | locRomSel;

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |=> ackN);

  assert_oe_in_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> !ackN);

  assert_owner_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dmaGnt, hostOwns}));

  assert_sel_needs_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
    anySel |-> hostOwns);

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({locRamSel, locRegSel, locRomSel}));

  assert_dma_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaGnt && !hostOwns) |=> dmaGnt);

  assert_host_after_idle_dma_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostOwns) |-> !$past(dmaReq));

  assert_host_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    anySel |=> hostOwns);

  assert_we_with_sel_R7: assert property (@(posedge clk) disable iff (!rstN)
    locWe |-> anySel);

endmodule

bind bpSlaveBridge bpSlaveBridgeChk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .ackN     (ackN),
  .adOe     (adOe),
  .dmaReq   (dmaReq),
  .dmaGnt   (dmaGnt),
  .hostOwns (hostOwns),
  .locWe    (locWe),
  .locRamSel(locRamSel),
  .locRegSel(locRegSel),
  .locRomSel(locRomSel)
);

// File: tb/bpSlaveBridge_tb_top.sv
`timescale 1ns/1ps
module bpSlaveBridge_tb_top;

  localparam int RamAw = 13;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [3:0]       slotId = 4'h3;
  logic             startN = 1'b1;
  logic             rdMode = 1'b0;
  logic [31:0]      adInN = '1;
  logic [31:0]      adOutN;
  logic             adOe;
  logic             ackN;
  logic             dmaReq = 1'b0;
  logic             dmaGnt;
  logic             hostOwns;
  logic [RamAw-1:0] locAddr;
  logic [15:0]      locWrData;
  logic [15:0]      locRdData;
  logic             locWe;
  logic             locRamSel;
  logic             locRegSel;
  logic             locRomSel;

  int nChecks = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;

  bpSlaveBridge #(.RamAw(RamAw)) dut_i (
    .clk(clk), .rstN(rstN), .slotId(slotId), .startN(startN), .rdMode(rdMode),
    .adInN(adInN), .adOutN(adOutN), .adOe(adOe), .ackN(ackN),
    .dmaReq(dmaReq), .dmaGnt(dmaGnt), .hostOwns(hostOwns),
    .locAddr(locAddr), .locWrData(locWrData), .locRdData(locRdData),
    .locWe(locWe), .locRamSel(locRamSel), .locRegSel(locRegSel), .locRomSel(locRomSel)
  );

  // local bus model: one-clock registered read
  logic [15:0] ram [256];
  logic [15:0] regs [16];
  logic [15:0] rom [256];
  logic [15:0] rdReg = '0;
  assign locRdData = rdReg;

  always @(posedge clk) begin
    if (locRamSel) begin
      if (locWe) ram[locAddr[7:0]] <= locWrData;
      rdReg <= ram[locAddr[7:0]];
    end else if (locRegSel) begin
      if (locWe) regs[locAddr[3:0]] <= locWrData;
      rdReg <= regs[locAddr[3:0]];
    end else if (locRomSel) begin
      rdReg <= rom[locAddr[7:0]];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] mkAddr(input logic [1:0] tgt, input int k);
    return {tgt, 20'(k), 2'b00};
  endfunction

  function automatic logic [31:0] pairToWord(input logic [15:0] e, input logic [15:0] o);
    return {o[7:0], o[15:8], e[7:0], e[15:8]};
  endfunction

  // called on a falling edge; returns on a falling edge
  task automatic busCycle(input logic [7:0] top, input logic [23:0] a, input bit rd,
                          input logic [31:0] w, input int maxWait,
                          output logic [31:0] r, output int lat, output bit acked,
                          output bit oeBad);
    acked = 1'b0;
    oeBad = 1'b0;
    r = '0;
    lat = 0;
    adInN  = {top, ~a};
    rdMode = rd;
    startN = 1'b0;
    @(negedge clk);
    startN = 1'b1;
    adInN  = rd ? (32'h5A5A_0F0F ^ {8'h0, a}) : ~w;
    for (int i = 1; i <= maxWait; i++) begin
      lat = i;
      if (adOe && (ackN || !rd)) oeBad = 1'b1;
      if (!ackN) begin
        acked = 1'b1;
        r = ~adOutN;
        if (rd && !adOe) oeBad = 1'b1;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    if (acked) begin
      check(ackN === 1'b1, "R9", "ack released next clock", 32'(ackN), 32'd1);
      check(adOe === 1'b0, "R9", "oe released next clock", 32'(adOe), 32'd0);
    end
    adInN = '1;
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [31:0] r;
    logic [31:0] w;
    logic [7:0]  hit;
    int lat;
    bit acked;
    bit oeBad;

    for (int i = 0; i < 256; i++) begin
      ram[i] = '0;
      rom[i] = 16'(i * 16'h0123 + 16'h005A);
    end
    for (int i = 0; i < 16; i++) regs[i] = '0;

    repeat (3) @(negedge clk);
    check(ackN === 1'b1, "R9", "reset ackN", 32'(ackN), 32'd1);
    check(adOe === 1'b0, "R9", "reset adOe", 32'(adOe), 32'd0);
    check(hostOwns === 1'b0 && dmaGnt === 1'b0, "R4", "reset grants",
          {30'd0, hostOwns, dmaGnt}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    hit = {4'hF, slotId};

    // R7 R10 R11: RAM write sweep, local layout checked in the model
    for (int k = 0; k < 128; k++) begin
      w = 32'(k) * 32'h01030507 + 32'h89AB_CDEF;
      busCycle(hit, mkAddr(2'b00, k), 1'b0, w, 20, r, lat, acked, oeBad);
      check(acked && lat == 6, "R11", "write latency", 32'(lat), 32'd6);
      check(!oeBad, "R9", "no oe on write", 32'(oeBad), 32'd0);
      check(ram[2*k] === {w[7:0], w[15:8]}, "R7", "even half", 32'(ram[2*k]), 32'({w[7:0], w[15:8]}));
      check(ram[2*k+1] === {w[23:16], w[31:24]}, "R7", "odd half", 32'(ram[2*k+1]), 32'({w[23:16], w[31:24]}));
    end

    // R3 R8 R2: RAM read sweep with garbage on the bus after the start
    for (int k = 0; k < 128; k++) begin
      busCycle(hit, mkAddr(2'b00, k), 1'b1, '0, 20, r, lat, acked, oeBad);
      check(acked && lat == 6, "R11", "read latency", 32'(lat), 32'd6);
      check(!oeBad, "R9", "oe exactly with read ack", 32'(oeBad), 32'd0);
      check(r === pairToWord(ram[2*k], ram[2*k+1]), "R8", "ram read word", r, pairToWord(ram[2*k], ram[2*k+1]));
    end

    // R10: register window write then read back
    for (int k = 0; k < 8; k++) begin
      w = 32'hC0DE_0000 + 32'(k * 16'h1111);
      busCycle(hit, mkAddr(2'b01, k), 1'b0, w, 20, r, lat, acked, oeBad);
      check(regs[2*k] === {w[7:0], w[15:8]}, "R10", "reg even", 32'(regs[2*k]), 32'({w[7:0], w[15:8]}));
    end
    for (int k = 0; k < 8; k++) begin
      busCycle(hit, mkAddr(2'b01, k), 1'b1, '0, 20, r, lat, acked, oeBad);
      check(r === pairToWord(regs[2*k], regs[2*k+1]), "R10", "reg read", r, pairToWord(regs[2*k], regs[2*k+1]));
    end

    // R10: whole ROM through both 1x encodings
    for (int k = 0; k < 128; k++) begin
      busCycle(hit, mkAddr((k % 2 == 0) ? 2'b10 : 2'b11, k), 1'b1, '0, 20, r, lat, acked, oeBad);
      check(r === pairToWord(rom[2*k], rom[2*k+1]), "R10", "rom read", r, pairToWord(rom[2*k], rom[2*k+1]));
    end

    // R1: every non-matching top byte is ignored (write attempt to word 5)
    w = pairToWord(ram[10], ram[11]);
    for (int t = 0; t < 256; t++) begin
      if (8'(t) != hit) begin
        busCycle(8'(t), mkAddr(2'b00, 5), 1'b0, 32'hFFFF_0000 ^ 32'(t), 8, r, lat, acked, oeBad);
        check(!acked && !oeBad, "R1", "mismatch ignored", {30'd0, acked, oeBad}, 32'd0);
      end
    end
    busCycle(hit, mkAddr(2'b00, 5), 1'b1, '0, 20, r, lat, acked, oeBad);
    check(r === w, "R1", "word 5 untouched", r, w);

    // R1: each slot identity accepts its own code
    for (int s = 0; s < 16; s++) begin
      slotId = 4'(s);
      busCycle({4'hF, 4'(s)}, mkAddr(2'b00, 5), 1'b1, '0, 20, r, lat, acked, oeBad);
      check(acked && r === w, "R1", "slot match", r, w);
    end
    slotId = 4'h3;

    // R5: DMA owns the bus before the start; host waits for release
    dmaReq = 1'b1;
    @(negedge clk);
    w = 32'h1234_5678;
    fork
      busCycle(hit, mkAddr(2'b00, 7), 1'b0, w, 40, r, lat, acked, oeBad);
      begin
        repeat (15) @(negedge clk);
        check(dmaGnt === 1'b1 && hostOwns === 1'b0, "R5", "dma keeps bus",
              {30'd0, dmaGnt, hostOwns}, 32'd2);
        dmaReq = 1'b0;
      end
    join
    check(acked && lat == 20, "R11", "latency after dma release", 32'(lat), 32'd20);
    check(ram[14] === {w[7:0], w[15:8]}, "R5", "write after dma", 32'(ram[14]), 32'({w[7:0], w[15:8]}));

    // R5: both request on the same clock, DMA wins
    fork
      busCycle(hit, mkAddr(2'b00, 7), 1'b1, '0, 40, r, lat, acked, oeBad);
      begin
        @(negedge clk);
        dmaReq = 1'b1;
        @(negedge clk);
        check(dmaGnt === 1'b1 && hostOwns === 1'b0, "R5", "simultaneous dma first",
              {30'd0, dmaGnt, hostOwns}, 32'd2);
        repeat (2) @(negedge clk);
        dmaReq = 1'b0;
      end
    join
    check(acked && lat == 9, "R11", "latency after short dma", 32'(lat), 32'd9);
    check(r === w, "R8", "read after contention", r, w);

    // R6: DMA request during the host's local accesses waits
    fork
      busCycle(hit, mkAddr(2'b00, 9), 1'b1, '0, 20, r, lat, acked, oeBad);
      begin
        repeat (3) @(negedge clk);
        dmaReq = 1'b1;
        @(negedge clk);
        check(hostOwns === 1'b1 && dmaGnt === 1'b0, "R6", "host holds second half",
              {30'd0, hostOwns, dmaGnt}, 32'd2);
        repeat (2) @(negedge clk);
        check(dmaGnt === 1'b1 && hostOwns === 1'b0, "R6", "dma granted after host",
              {30'd0, dmaGnt, hostOwns}, 32'd2);
        dmaReq = 1'b0;
      end
    join
    check(acked && lat == 6, "R6", "host cycle unaffected", 32'(lat), 32'd6);
    check(r === pairToWord(ram[18], ram[19]), "R8", "word 9 read", r, pairToWord(ram[18], ram[19]));

    repeat (3) @(negedge clk);
    finish();
  end

endmodule